// File: doc/BRIEF.md
# Palettized Pixel Fetch and Unpack

This block feeds the colour stage of a raster display. It reads a packed framebuffer in which every pixel is a one-byte palette index. Memory is read one 64-bit word (eight pixels) at a time through an address generator that walks the frame word by word and wraps at the end of the frame. Each word returned by memory lands in a holding slot. A second register presents one byte per pixel clock and takes the held word the moment its eighth byte has been shown, so the pixel stream has no gaps.

Every byte selects one of 256 palette entries. Each entry holds 12 bits of colour (4 bits per primary), chosen from 4,096 possible colours. The palette is loaded through a write port in the pixel clock domain. The colour output is registered and trails the display-enable input by one clock; a delayed enable is provided alongside it. If the next word is still missing when it is needed, the block raises a sticky underrun flag and shows black until the next line begins.

Raster timing, the video DAC, clock generation and memory arbitration sit outside the block. Memory is modelled as a request pulse with an address, followed by a one-cycle data strobe some cycles later. At most one request is outstanding at any time.

Top module: `pix_fetch_unpack`

## Requirements
- R1: While in reset, and after reset until the first frame-start pulse, `mem_req_o` is 0. During reset `de_o`, `underrun_o` and `color_o` are 0.
- R2: The first request after a frame-start pulse carries byte address BASE_ADDR. Each later request carries the previous address plus 8.
- R3: After the last word of the frame (H_PIX*V_LINES/8 words), the next request address wraps back to BASE_ADDR.
- R4: Pixels leave each word least significant byte first: byte k sits at bits [8k+7:8k]. A pixel shown in cycle n with `de_i`=1 appears on `color_o` as its palette entry in cycle n+1. `de_o` in cycle n+1 equals `de_i` in cycle n.
- R5: The pixel stream has no gap. The held word moves into the shifting register in the same cycle as the eighth byte of the current word is displayed, and that cycle also issues the next memory request.
- R6: If a pixel is requested (`de_i`=1) while no word is available, `underrun_o` becomes 1 from the next cycle. It stays 1, and `color_o` stays 0, until the cycle after a `line_start_i` pulse.
- R7: A palette write and a display read of the same entry in the same cycle show the old colour. Later reads show the new colour.
- R8: In any cycle following a cycle with `de_i`=0, `color_o` is 12'h000.
- R9: A frame-start pulse discards any word still in flight and restarts fetching at BASE_ADDR. The first pixels of the new frame come from the word at BASE_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse that restarts the frame at BASE_ADDR |
| line_start_i | input | 1 | One-cycle pulse at the start of each line; clears underrun |
| de_i | input | 1 | Display enable; one pixel is consumed per cycle while high |
| mem_req_o | output | 1 | Memory read request, one-cycle pulse |
| mem_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_valid_i | input | 1 | Read data strobe for the outstanding request |
| mem_data_i | input | WORD_W | Read data, eight pixel indices |
| pal_we_i | input | 1 | Palette write enable |
| pal_addr_i | input | PIX_W | Palette entry to write |
| pal_data_i | input | COL_W | Colour to write |
| de_o | output | 1 | Display enable delayed to match color_o |
| color_o | output | COL_W | Pixel colour (4 bits each of red, green, blue) |
| underrun_o | output | 1 | Sticky underrun flag, cleared by line start |

## Verification
The hardest situation to reach from the ports is a frame restart while a fetch is still in flight. The stale word must arrive after the restart and be thrown away, without being taken for the first word of the new frame. The bench reaches this case by letting a request go out on the eighth pixel of a word under a five-cycle memory latency and pulsing frame start on the very next cycle. It then checks that the next request goes to the base address and that the first sixteen pixels come from the base words. Underrun is forced in a similar way: the memory model holds back a response until both registers have drained.

// File: rtl/pff_pkg.sv
`timescale 1ns/1ps
package pff_pkg;
  localparam int unsigned PFF_WORD_W = 64;
  localparam int unsigned PFF_PIX_W  = 8;
  localparam int unsigned PFF_COL_W  = 12;
  localparam int unsigned PFF_ADDR_W = 32;

  function automatic int unsigned pff_words(input int unsigned h, input int unsigned v,
                                            input int unsigned ppw);
    return (h * v) / ppw;
  endfunction
endpackage

// File: rtl/pff_addr_gen.sv
`timescale 1ns/1ps
module pff_addr_gen #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BASE_ADDR = 0,
  parameter int unsigned STEP      = 8,
  parameter int unsigned WORDS     = 98304
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned CNT_W = ($clog2(WORDS) > 0) ? $clog2(WORDS) : 1;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [CNT_W-1:0]  wcnt_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= BASE;
      wcnt_q <= '0;
    end else if (restart_i) begin
      addr_q <= BASE;
      wcnt_q <= '0;
    end else if (adv_i) begin
      if (wcnt_q == CNT_W'(WORDS - 1)) begin
        addr_q <= BASE;
        wcnt_q <= '0;
      end else begin
        addr_q <= addr_q + ADDR_W'(STEP);
        wcnt_q <= wcnt_q + CNT_W'(1);
      end
    end
  end

  assign addr_o = addr_q;

  // R3
  addr_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_q - BASE) < ADDR_W'(WORDS * STEP));
endmodule

// File: rtl/pff_unpack.sv
`timescale 1ns/1ps
module pff_unpack #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned PIX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  input  logic              de_i,
  input  logic              mem_valid_i,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic              req_o,
  output logic [PIX_W-1:0]  idx_o,
  output logic              pix_ok_o,
  output logic              underrun_o
);
  localparam int unsigned NB   = WORD_W / PIX_W;
  localparam int unsigned CW   = ($clog2(NB) > 0) ? $clog2(NB) : 1;

  logic              run_q, pend_q, drop_q, stg_vld_q, use_vld_q, und_q;
  logic [WORD_W-1:0] stg_q, use_q;
  logic [CW-1:0]     cnt_q;
  logic              last_b, xfer;

  assign last_b = (cnt_q == CW'(NB - 1));
  // staging moves over when use is empty, or as its last byte is shown
  assign xfer   = stg_vld_q && (!use_vld_q || (de_i && last_b));
  assign req_o  = run_q && !pend_q && !drop_q && !frame_start_i && (!stg_vld_q || xfer);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      pend_q    <= 1'b0;
      drop_q    <= 1'b0;
      stg_vld_q <= 1'b0;
      use_vld_q <= 1'b0;
      und_q     <= 1'b0;
      stg_q     <= '0;
      use_q     <= '0;
      cnt_q     <= '0;
    end else if (frame_start_i) begin
      run_q     <= 1'b1;
      pend_q    <= 1'b0;
      drop_q    <= pend_q && !mem_valid_i;
      stg_vld_q <= 1'b0;
      use_vld_q <= 1'b0;
      und_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (req_o)            pend_q <= 1'b1;
      else if (mem_valid_i) pend_q <= 1'b0;
      if (mem_valid_i)      drop_q <= 1'b0;

      if (mem_valid_i && !drop_q) begin
        stg_q     <= mem_data_i;
        stg_vld_q <= 1'b1;
      end else if (xfer) begin
        stg_vld_q <= 1'b0;
      end

      if (xfer) begin
        use_q     <= stg_q;
        use_vld_q <= 1'b1;
        cnt_q     <= '0;
      end else if (de_i && use_vld_q) begin
        use_q <= use_q >> PIX_W;
        cnt_q <= cnt_q + CW'(1);
        if (last_b) use_vld_q <= 1'b0;
      end

      if (line_start_i)                      und_q <= 1'b0;
      else if (run_q && de_i && !use_vld_q)  und_q <= 1'b1;
    end
  end

  assign idx_o      = use_q[PIX_W-1:0];
  assign pix_ok_o   = use_vld_q && !und_q;
  assign underrun_o = und_q;

  // R6
  und_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    und_q && !line_start_i && !frame_start_i |=> und_q);
  // R5
  stg_no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i && !drop_q |-> !stg_vld_q);
  // R5
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
endmodule

// File: rtl/pff_palette.sv
`timescale 1ns/1ps
module pff_palette #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned COL_W = 12
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [COL_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [COL_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [COL_W-1:0] mem_q [DEPTH];
  logic [COL_W-1:0] rd_q;

  // read-before-write: same-entry access returns the old colour
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/pix_fetch_unpack.sv
`timescale 1ns/1ps
module pix_fetch_unpack
  import pff_pkg::*;
#(
  parameter int unsigned WORD_W    = PFF_WORD_W,
  parameter int unsigned PIX_W     = PFF_PIX_W,
  parameter int unsigned COL_W     = PFF_COL_W,
  parameter int unsigned ADDR_W    = PFF_ADDR_W,
  parameter int unsigned H_PIX     = 1024,
  parameter int unsigned V_LINES   = 768,
  parameter int unsigned BASE_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  input  logic              de_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [WORD_W-1:0] mem_data_i,
  input  logic              pal_we_i,
  input  logic [PIX_W-1:0]  pal_addr_i,
  input  logic [COL_W-1:0]  pal_data_i,
  output logic              de_o,
  output logic [COL_W-1:0]  color_o,
  output logic              underrun_o
);
  localparam int unsigned PIX_PER_WORD = WORD_W / PIX_W;
  localparam int unsigned STEP         = WORD_W / 8;
  localparam int unsigned WORDS        = pff_words(H_PIX, V_LINES, PIX_PER_WORD);

  logic             req;
  logic [PIX_W-1:0] idx;
  logic             pix_ok;
  logic [COL_W-1:0] pal_rd;
  logic             de_q, blank_q;

  pff_addr_gen #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STEP(STEP), .WORDS(WORDS)) addr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(frame_start_i), .adv_i(req), .addr_o(mem_addr_o));

  pff_unpack #(.WORD_W(WORD_W), .PIX_W(PIX_W)) unpack_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i), .line_start_i(line_start_i),
    .de_i(de_i), .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i), .req_o(req),
    .idx_o(idx), .pix_ok_o(pix_ok), .underrun_o(underrun_o));

  pff_palette #(.IDX_W(PIX_W), .COL_W(COL_W)) pal_i (
    .clk_i(clk_i), .we_i(pal_we_i), .waddr_i(pal_addr_i), .wdata_i(pal_data_i),
    .raddr_i(idx), .rdata_o(pal_rd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q    <= 1'b0;
      blank_q <= 1'b1;
    end else begin
      de_q    <= de_i;
      blank_q <= !(de_i && pix_ok);
    end
  end

  assign mem_req_o = req;
  assign de_o      = de_q;
  assign color_o   = blank_q ? '0 : pal_rd;

  // R8
  blank_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> color_o == '0);
  // R6
  black_in_underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(underrun_o) |-> color_o == '0);
  // R2
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((mem_addr_o - ADDR_W'(BASE_ADDR)) % ADDR_W'(STEP)) == '0);
endmodule

// File: tb/pix_fetch_unpack_tb_top.sv
`timescale 1ns/1ps
module pix_fetch_unpack_tb_top;
  localparam int H = 16;
  localparam int V = 2;
  localparam int FRAME_PIX = H * V;
  localparam int FRAME_BYTES = FRAME_PIX;
  localparam int ROWS = 4;
  // {latency, pixel run length}
  localparam logic [15:0] VEC [ROWS] = '{{8'd1, 8'd16}, {8'd2, 8'd24}, {8'd4, 8'd40}, {8'd7, 8'd16}};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_start_i = 1'b0, line_start_i = 1'b0, de_i = 1'b0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [63:0] mem_data_i = '0;
  logic        pal_we_i = 1'b0;
  logic [7:0]  pal_addr_i = '0;
  logic [11:0] pal_data_i = '0;
  logic        de_o;
  logic [11:0] color_o;
  logic        underrun_o;

  pix_fetch_unpack #(.H_PIX(H), .V_LINES(V)) dut_i (.*);

  always #4 clk_i = ~clk_i;

  int total = 0, bad = 0;
  logic fs_d = 0, ls_d = 0, de_d = 0, we_d = 0;
  logic [7:0]  wa_d = '0;
  logic [11:0] wd_d = '0;
  logic [11:0] pal_m [256];
  int lat = 1, resp_cnt = 0, pix_ptr = 0, req_n = 0;
  logic [31:0] resp_addr = '0, exp_addr = '0;
  bit hold = 0, chk_col = 0, r5_en = 1;
  logic [11:0] exp_prev = '0;
  string tag_prev = "R8", cur_tag = "R4", first_tag = "R2";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] word_at(input logic [31:0] a);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = 8'(a + 32'(k));
    return w;
  endfunction

  function automatic logic [11:0] pal_init(input int i);
    return 12'((i * 37 + 11) & 12'hfff);
  endfunction

  task automatic step();
    @(negedge clk_i);
    frame_start_i = fs_d; line_start_i = ls_d; de_i = de_d;
    pal_we_i = we_d; pal_addr_i = wa_d; pal_data_i = wd_d;
    mem_valid_i = 1'b0;
    if (resp_cnt > 0 && !hold) begin
      resp_cnt--;
      if (resp_cnt == 0) begin
        mem_valid_i = 1'b1;
        mem_data_i  = word_at(resp_addr);
      end
    end
    #1;
    if (chk_col) chk(color_o == exp_prev, tag_prev, color_o, exp_prev);
    if (mem_req_o) begin
      chk(mem_addr_o == exp_addr,
          (req_n == 0) ? first_tag : ((exp_addr == 0) ? "R3" : "R2"), mem_addr_o, exp_addr);
      if (chk_col && r5_en && de_d) chk((pix_ptr % 8) == 7, "R5", pix_ptr % 8, 7);
      req_n++;
      resp_cnt  = lat;
      resp_addr = mem_addr_o;
      exp_addr  = (exp_addr + 32'd8) % FRAME_BYTES;
    end
    if (de_d) begin
      exp_prev = pal_m[pix_ptr % FRAME_PIX];
      tag_prev = cur_tag;
      pix_ptr++;
    end else begin
      exp_prev = '0;
      tag_prev = "R8";
    end
    if (we_d) pal_m[wa_d] = wd_d;
  endtask

  task automatic restart_frame();
    pix_ptr = 0; exp_addr = '0; req_n = 0;
    de_d = 0; fs_d = 1; step(); fs_d = 0;
  endtask

  initial begin
    #(8 * 150000);
    $display("FAIL R1: actual=watchdog expected=finish");
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) pal_m[i] = 'x;
    repeat (3) @(negedge clk_i);
    #1;
    chk(mem_req_o == 1'b0, "R1", mem_req_o, 0);
    chk(de_o == 1'b0, "R1", de_o, 0);
    chk(color_o == '0, "R1", color_o, 0);
    chk(underrun_o == 1'b0, "R1", underrun_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // no fetch before the first frame start
    for (int i = 0; i < 3; i++) begin
      step();
      chk(mem_req_o == 1'b0, "R1", mem_req_o, 0);
    end

    // palette load
    for (int i = 0; i < 256; i++) begin
      we_d = 1; wa_d = 8'(i); wd_d = pal_init(i); step();
    end
    we_d = 0;
    chk_col = 1;

    // table of latency / run length vectors
    for (int r = 0; r < ROWS; r++) begin
      lat = int'(VEC[r][15:8]);
      restart_frame();
      repeat (2 * lat + 4) step();
      for (int p = 0; p < int'(VEC[r][7:0]); p++) begin
        de_d = 1;
        if (r == 2 && (pix_ptr == 5 || pix_ptr == 37)) begin
          cur_tag = "R7";
          we_d = (pix_ptr == 5); wa_d = 8'd5; wd_d = 12'h5A3;
        end else begin
          cur_tag = "R4"; we_d = 0;
        end
        step();
      end
      de_d = 0; we_d = 0; cur_tag = "R4";
      repeat (2) step();
    end

    // R9: restart with a fetch in flight
    lat = 5;
    restart_frame();
    repeat (2 * lat + 4) step();
    de_d = 1;
    repeat (8) step();
    first_tag = "R9";
    restart_frame();
    repeat (3 * lat + 6) step();
    cur_tag = "R9";
    de_d = 1;
    repeat (16) step();
    de_d = 0; cur_tag = "R4"; first_tag = "R2";
    repeat (2) step();

    // R6: memory withheld until both registers drain
    lat = 2;
    restart_frame();
    repeat (2 * lat + 4) step();
    hold = 1;
    de_d = 1;
    repeat (16) step();
    r5_en = 0;
    step();                     // pixel with nothing to show
    exp_prev = '0; tag_prev = "R6";
    step();
    exp_prev = '0; tag_prev = "R6";
    chk(underrun_o == 1'b1, "R6", underrun_o, 1);
    hold = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      exp_prev = '0; tag_prev = "R6";
      chk(underrun_o == 1'b1, "R6", underrun_o, 1);
    end
    de_d = 0; ls_d = 1;
    step();
    ls_d = 0;
    step();
    chk(underrun_o == 1'b0, "R6", underrun_o, 0);
    r5_en = 1;
    repeat (2) step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule